// File: doc/BRIEF.md
# Pipelined 4x4 inverse sine transform with reconstruction

This block turns one 4x4 block of signed transform coefficients into sixteen reconstructed 8-bit pixels. It applies the inverse 4-point discrete sine transform that video coding uses for small intra luma residuals in two separable passes. The first pass works down the columns and the second pass works along the rows. After each pass every value is rounded, shifted right and saturated to signed 16 bits. The final residual is then added to the matching prediction sample and clamped to the 8-bit pixel range.

A whole block moves as one transaction on a valid/ready handshake. The coefficients, the prediction and the result are flat packed vectors in row-major order. Three register stages separate the input from the output. When the downstream side applies backpressure, the whole pipeline stalls together.

Top module: `isine4_recon`

## Requirements
- R1: After reset, `out_valid` is low and `in_ready` is high.
- R2: For a 1-D input s0..s3 the kernel gives y0 = 29*s0 + 74*s1 + 84*s2 + 55*s3, y1 = 55*s0 + 74*s1 - 29*s2 - 84*s3, y2 = 74*s0 - 74*s2 + 74*s3 and y3 = 84*s0 - 74*s1 + 55*s2 - 29*s3. The first pass applies it to column c (s_i = coefficient at row i, column c) and writes y_k to intermediate row k, column c, after adding 64 and shifting arithmetically right by 7.
- R3: Every intermediate and every final residual is saturated to the range -32768..32767, so extreme coefficients never wrap.
- R4: The second pass applies the same kernel to intermediate row r (s_i = intermediate at row r, column i). It gives the residual at row r, column k as y_k, after adding 2048 and shifting arithmetically right by 12, and then saturates it.
- R5: Each output pixel is the residual plus the unsigned prediction sample at the same position, clamped to 0..255.
- R6: Element (row r, column c) sits at bit offset 16*(4r+c) of `in_coef`, and at bit offset 8*(4r+c) of `in_pred` and `out_pix`.
- R7: With `out_ready` held high, a block is accepted every cycle and its result appears exactly 3 cycles after acceptance. No more than 3 blocks are ever in flight.
- R8: While `out_valid` is high and `out_ready` is low, `out_pix` and `out_valid` hold and `in_ready` is low.
- R9: Every accepted block yields exactly one output, in acceptance order.
- R10: A block of all-zero coefficients produces the prediction unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input block present |
| in_ready | output | 1 | Block accepted when high with in_valid |
| in_coef | input | 256 | 16 signed 16-bit coefficients, row-major |
| in_pred | input | 128 | 16 unsigned 8-bit prediction samples, row-major |
| out_valid | output | 1 | Result block present |
| out_ready | input | 1 | Downstream takes the result |
| out_pix | output | 128 | 16 reconstructed 8-bit pixels, row-major |

## Verification
A wrong coefficient sign, basis constant or transpose shows up as wrong pixels in the block's result 3 cycles after acceptance. A missing saturation or a wrong rounding offset shows up only under extreme or boundary coefficients, so directed blocks drive full-scale values. A fault in the stall logic shows as a result that changes, vanishes or repeats while `out_ready` is low. It is seen on the first stalled cycle, or as a mismatch in the sequence of results a few blocks later.

// File: rtl/isine4_pkg.sv
package isine4_pkg;
  localparam int TAPS  = 4;
  localparam int ELEMS = TAPS * TAPS;

  // Sine basis weight for output k, input i
  function automatic int basis(input int k, input int i);
    int w;
    case ({k[1:0], i[1:0]})
      4'h0: w = 29;   4'h1: w = 74;   4'h2: w = 84;   4'h3: w = 55;
      4'h4: w = 55;   4'h5: w = 74;   4'h6: w = -29;  4'h7: w = -84;
      4'h8: w = 74;   4'h9: w = 0;    4'hA: w = -74;  4'hB: w = 74;
      4'hC: w = 84;   4'hD: w = -74;  4'hE: w = 55;   default: w = -29;
    endcase
    return w;
  endfunction
endpackage

// File: rtl/isine4_kernel.sv
module isine4_kernel #(
  parameter int IN_W  = 16,
  parameter int OUT_W = 16,
  parameter int ACC_W = 32,
  parameter int SHIFT = 7
) (
  input  logic [isine4_pkg::TAPS*IN_W-1:0]  vec_i,
  output logic [isine4_pkg::TAPS*OUT_W-1:0] vec_o
);
  import isine4_pkg::*;

  localparam logic signed [ACC_W-1:0] HALF = ACC_W'(1) << (SHIFT - 1);
  localparam logic signed [ACC_W-1:0] MAXV = ACC_W'((1 << (OUT_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] MINV = -MAXV - ACC_W'(1);

  for (genvar k = 0; k < TAPS; k++) begin : g_out
    logic signed [ACC_W-1:0] acc;
    logic signed [ACC_W-1:0] rnd;
    logic signed [OUT_W-1:0] sat;

    always_comb begin
      acc = '0;
      for (int i = 0; i < TAPS; i++) begin
        acc = acc + ACC_W'(basis(k, i)) * ACC_W'(signed'(vec_i[i*IN_W +: IN_W]));
      end
      rnd = (acc + HALF) >>> SHIFT;
      if (rnd > MAXV)      sat = MAXV[OUT_W-1:0];
      else if (rnd < MINV) sat = MINV[OUT_W-1:0];
      else                 sat = rnd[OUT_W-1:0];
    end

    assign vec_o[k*OUT_W +: OUT_W] = sat;
  end
endmodule

// File: rtl/isine4_addclip.sv
module isine4_addclip #(
  parameter int RES_W = 16,
  parameter int PIX_W = 8,
  parameter int N     = 16
) (
  input  logic [N*RES_W-1:0] res_i,
  input  logic [N*PIX_W-1:0] pred_i,
  output logic [N*PIX_W-1:0] pix_o
);
  localparam logic signed [RES_W:0] PMAX = (RES_W+1)'((1 << PIX_W) - 1);

  for (genvar e = 0; e < N; e++) begin : g_el
    logic signed [RES_W:0]   sum;
    logic        [PIX_W-1:0] clip;

    always_comb begin
      sum = (RES_W+1)'(signed'(res_i[e*RES_W +: RES_W]))
          + signed'((RES_W+1)'(pred_i[e*PIX_W +: PIX_W]));
      if (sum < 0)         clip = '0;
      else if (sum > PMAX) clip = PMAX[PIX_W-1:0];
      else                 clip = sum[PIX_W-1:0];
    end

    assign pix_o[e*PIX_W +: PIX_W] = clip;
  end
endmodule

// File: rtl/isine4_recon.sv
module isine4_recon #(
  parameter int COEF_W  = 16,
  parameter int PIX_W   = 8,
  parameter int ACC_W   = 32,
  parameter int SHIFT_A = 7,
  parameter int SHIFT_B = 12
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 in_valid,
  output logic                                 in_ready,
  input  logic [isine4_pkg::ELEMS*COEF_W-1:0]  in_coef,
  input  logic [isine4_pkg::ELEMS*PIX_W-1:0]   in_pred,
  output logic                                 out_valid,
  input  logic                                 out_ready,
  output logic [isine4_pkg::ELEMS*PIX_W-1:0]   out_pix
);
  import isine4_pkg::*;

  localparam int N     = ELEMS;
  localparam int VEC_W = TAPS * COEF_W;

  // Pipeline control: one shared stall for every stage
  logic v_a, v_b, v_c;
  logic advance;

  assign advance   = !v_c || out_ready;
  assign in_ready  = advance;
  assign out_valid = v_c;

  always_ff @(posedge clk) begin
    if (rst) begin
      v_a <= 1'b0;
      v_b <= 1'b0;
      v_c <= 1'b0;
    end else if (advance) begin
      v_a <= in_valid;
      v_b <= v_a;
      v_c <= v_b;
    end
  end

  // Pass A: columns of the input block
  logic [VEC_W-1:0]    col_vec [TAPS];
  logic [VEC_W-1:0]    col_res [TAPS];
  logic [N*COEF_W-1:0] pass_a;

  for (genvar c = 0; c < TAPS; c++) begin : g_col
    for (genvar i = 0; i < TAPS; i++) begin : g_gather
      assign col_vec[c][i*COEF_W +: COEF_W] = in_coef[(i*TAPS+c)*COEF_W +: COEF_W];
      assign pass_a[(i*TAPS+c)*COEF_W +: COEF_W] = col_res[c][i*COEF_W +: COEF_W];
    end
    isine4_kernel #(
      .IN_W(COEF_W), .OUT_W(COEF_W), .ACC_W(ACC_W), .SHIFT(SHIFT_A)
    ) u_kcol (
      .vec_i(col_vec[c]),
      .vec_o(col_res[c])
    );
  end

  logic [N*COEF_W-1:0] mid_q;
  logic [N*PIX_W-1:0]  pred_a;

  always_ff @(posedge clk) begin
    if (advance) begin
      mid_q  <= pass_a;
      pred_a <= in_pred;
    end
  end

  // Pass B: rows of the intermediate block (transposed reading)
  logic [N*COEF_W-1:0] pass_b;

  for (genvar r = 0; r < TAPS; r++) begin : g_row
    isine4_kernel #(
      .IN_W(COEF_W), .OUT_W(COEF_W), .ACC_W(ACC_W), .SHIFT(SHIFT_B)
    ) u_krow (
      .vec_i(mid_q[r*VEC_W +: VEC_W]),
      .vec_o(pass_b[r*VEC_W +: VEC_W])
    );
  end

  logic [N*COEF_W-1:0] res_q;
  logic [N*PIX_W-1:0]  pred_b;

  always_ff @(posedge clk) begin
    if (advance) begin
      res_q  <= pass_b;
      pred_b <= pred_a;
    end
  end

  // Reconstruction: add prediction and clamp
  logic [N*PIX_W-1:0] pix_next;

  isine4_addclip #(
    .RES_W(COEF_W), .PIX_W(PIX_W), .N(N)
  ) u_add (
    .res_i (res_q),
    .pred_i(pred_b),
    .pix_o (pix_next)
  );

  always_ff @(posedge clk) begin
    if (advance) out_pix <= pix_next;
  end
endmodule

// File: rtl/isine4_recon_chk.sv
module isine4_recon_chk #(
  parameter int PIX_W = 8
) (
  input logic                                clk,
  input logic                                rst,
  input logic                                in_valid,
  input logic                                in_ready,
  input logic                                out_valid,
  input logic                                out_ready,
  input logic [isine4_pkg::ELEMS*PIX_W-1:0]  out_pix
);
  logic [2:0] occ;

  always_ff @(posedge clk) begin
    if (rst) occ <= '0;
    else     occ <= occ + 3'(in_valid && in_ready) - 3'(out_valid && out_ready);
  end

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && in_ready)); // R1

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pix))); // R8

  AST_STALL_BLOCK: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready); // R8

  AST_INFLIGHT_MAX: assert property (@(posedge clk) disable iff (rst)
    occ <= 3'd3); // R7

  AST_NO_PHANTOM: assert property (@(posedge clk) disable iff (rst)
    (occ == 3'd0) |-> !out_valid); // R9

  AST_PIX_KNOWN: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !$isunknown(out_pix)); // R5
endmodule

bind isine4_recon isine4_recon_chk #(.PIX_W(PIX_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_pix  (out_pix)
);

// File: tb/sim_isine4_recon.sv
module sim_isine4_recon;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [255:0] in_coef = '0;
  logic [127:0] in_pred = '0;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic [127:0] out_pix;

  always #(CLK_PERIOD/2) clk = ~clk;

  isine4_recon u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_coef(in_coef), .in_pred(in_pred), .out_valid(out_valid),
    .out_ready(out_ready), .out_pix(out_pix)
  );

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit lat_mode = 1'b0;
  bit hold_pending = 1'b0;
  logic [127:0] held;

  logic [127:0] exp_q[$];
  string        tag_q[$];
  int           cyc_q[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic longint wt(input int k, input int i);
    int m[16] = '{29, 74, 84, 55, 55, 74, -29, -84, 74, 0, -74, 74, 84, -74, 55, -29};
    return longint'(m[k*4+i]);
  endfunction

  function automatic longint sat16(input longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic logic [127:0] model(input logic [255:0] c, input logic [127:0] p);
    longint t[16];
    longint x;
    longint y;
    logic [127:0] o;
    for (int col = 0; col < 4; col++)
      for (int k = 0; k < 4; k++) begin
        x = 0;
        for (int i = 0; i < 4; i++)
          x += wt(k, i) * longint'(signed'(c[(i*4+col)*16 +: 16]));
        t[k*4+col] = sat16((x + 64) >>> 7);
      end
    for (int r = 0; r < 4; r++)
      for (int m = 0; m < 4; m++) begin
        x = 0;
        for (int i = 0; i < 4; i++) x += wt(m, i) * t[r*4+i];
        y = sat16((x + 2048) >>> 12) + longint'(p[(r*4+m)*8 +: 8]);
        if (y < 0) y = 0;
        if (y > 255) y = 255;
        o[(r*4+m)*8 +: 8] = 8'(y);
      end
    return o;
  endfunction

  task automatic step(input logic v, input logic [255:0] c, input logic [127:0] p,
                      input logic ordy, input string tag, output bit took);
    logic [127:0] e;
    @(negedge clk);
    in_valid = v; in_coef = c; in_pred = p; out_ready = ordy;
    #1;
    cyc++;
    if (hold_pending) begin
      chk(out_valid, "R8", "valid dropped during stall", 128'(out_valid), 128'(1));
      chk(out_pix == held, "R8", "pixels changed during stall", out_pix, held);
      hold_pending = 1'b0;
    end
    if (out_valid && !out_ready) begin
      chk(!in_ready, "R8", "in_ready high during stall", 128'(in_ready), 128'(0));
      hold_pending = 1'b1;
      held = out_pix;
    end
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R9", "unexpected output", out_pix, '0);
      end else begin
        e = exp_q.pop_front();
        chk(out_pix == e, tag_q.pop_front(), "pixel block", out_pix, e);
        if (lat_mode)
          chk(cyc - cyc_q[0] == 3, "R7", "latency", 128'(cyc - cyc_q[0]), 128'(3));
        void'(cyc_q.pop_front());
      end
    end
    took = v && in_ready;
    if (took) begin
      exp_q.push_back(model(c, p));
      tag_q.push_back(tag);
      cyc_q.push_back(cyc);
    end
  endtask

  task automatic send(input logic [255:0] c, input logic [127:0] p,
                      input bit rnd_ready, input string tag);
    bit took;
    do step(1'b1, c, p, rnd_ready ? (($urandom % 4) != 0) : 1'b1, tag, took);
    while (!took);
  endtask

  task automatic idle(input int n, input bit rnd_ready);
    bit took;
    for (int i = 0; i < n; i++)
      step(1'b0, '0, '0, rnd_ready ? (($urandom % 3) != 0) : 1'b1, "R9", took);
  endtask

  function automatic logic [255:0] rand_coef(input int mode);
    logic [255:0] c;
    for (int e = 0; e < 16; e++) begin
      case (mode)
        0: c[e*16 +: 16] = 16'(int'($urandom % 1024) - 512);
        1: c[e*16 +: 16] = 16'($urandom);
        default: case ($urandom % 3)
          0: c[e*16 +: 16] = 16'h7FFF;
          1: c[e*16 +: 16] = 16'h8000;
          default: c[e*16 +: 16] = 16'h0000;
        endcase
      endcase
    end
    return c;
  endfunction

  function automatic logic [127:0] rand_pred();
    logic [127:0] p;
    for (int e = 0; e < 4; e++) p[e*32 +: 32] = $urandom;
    return p;
  endfunction

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    total++; bad++;
    $display("FAIL R9 watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [255:0] c;
    logic [127:0] p;
    void'($urandom(32'd2024));
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk(!out_valid, "R1", "out_valid after reset", 128'(out_valid), 128'(0));
    chk(in_ready, "R1", "in_ready after reset", 128'(in_ready), 128'(1));

    lat_mode = 1'b1;
    p = rand_pred();
    send('0, p, 1'b0, "R10");
    c = '0; c[15:0] = 16'sd64;
    send(c, rand_pred(), 1'b0, "R2");
    c = '0; c[1*16 +: 16] = 16'sd300;
    send(c, rand_pred(), 1'b0, "R6");
    c = '0; c[14*16 +: 16] = -16'sd1000;
    send(c, rand_pred(), 1'b0, "R6");
    send({16{16'h7FFF}}, {16{8'd128}}, 1'b0, "R3");
    send({16{16'h8000}}, {16{8'd128}}, 1'b0, "R3");
    send({16{16'h7FFF}}, {16{8'd255}}, 1'b0, "R5");
    send({16{16'h8000}}, {16{8'd0}}, 1'b0, "R5");
    c = '0; c[5*16 +: 16] = 16'sd200; c[10*16 +: 16] = -16'sd200;
    send(c, {16{8'd100}}, 1'b0, "R4");
    for (int n = 0; n < 40; n++) send(rand_coef(n % 3), rand_pred(), 1'b0, "R4");
    idle(6, 1'b0);
    lat_mode = 1'b0;

    for (int n = 0; n < 300; n++) begin
      send(rand_coef(n % 3), rand_pred(), 1'b1, (n % 2) ? "R8" : "R2");
      if (($urandom % 5) == 0) idle(1 + ($urandom % 3), 1'b1);
    end
    idle(30, 1'b0);
    chk(exp_q.size() == 0, "R9", "blocks left undelivered",
        128'(exp_q.size()), 128'(0));
    finish_run();
  end
endmodule